// File: doc/BRIEF.md
# Baud-Rate Timing Recovery Loop (Quarter-Rate Digital Core)

This block is the digital half of a clock-and-data-recovery loop for a serial receiver that takes one sample per symbol. Two interleaved sampling slices each deliver two symbols per core clock. Each symbol carries a data decision and the sign of the error against the expected level. The core puts the four symbols back in time order and forms a type-A Mueller-Müller timing vote from every adjacent symbol pair. That includes the pair that spans the previous word and the current one. The vote is then filtered by a second-order loop.

The proportional term (vote times Kp) goes straight into the phase accumulator input in the same cycle. It does not pass through the integral register, so a vote reaches the rotator code after a single register stage. The integral term builds up vote times Ki, is clamped to a programmable limit, and is added to the phase on every cycle. It carries the frequency offset: the default widths reach about ±3.1 % of the bit rate. The upper bits of the wrapping phase accumulator steer the receiver's only phase rotator. The integral register is also brought out so it can be observed.

Top module: `mm_cdr_top`

## Requirements
- R1: Each word carries four symbols. Symbol order in time is slice A lane 0, slice B lane 0, slice A lane 1, slice B lane 1. Lane i of a slice sits at bit i of that slice's decision and error inputs. Bit value 1 stands for +1 and bit value 0 stands for −1.
- R2: Each adjacent symbol pair (k−1, k) contributes (e[k]·d[k−1] − e[k−1]·d[k]) / 2, which is −1, 0 or +1. The word vote is the sum over four pairs, in the range −4 to +4. The first of those pairs joins the last symbol of the previous word to the first symbol of this word.
- R3: In the first word after reset there is no previous symbol, so the pair across the word boundary contributes 0.
- R4: On every cycle the phase accumulator adds vote·Kp plus the current integral value. A word's proportional effect shows in rot_code at the first clock edge that samples the word.
- R5: The integral register adds vote·Ki on every cycle that is not frozen. The new value enters the phase sum from the following cycle onward.
- R6: The integral value is clamped to the range [−int_limit, +int_limit]. The clamp is applied to the updated sum.
- R7: While freeze is 1, the integral register keeps its value and the proportional path keeps working.
- R8: The phase accumulator is PH_W bits wide (default 16) and wraps modulo 2^PH_W. rot_code is its upper CODE_W bits (default 7, which gives 128 steps).
- R9: A synchronous active-high reset clears the phase accumulator, the integral register and the boundary history. While reset is held, rot_code and int_value read 0.
- R10: int_value always shows the current integral register as a two's-complement number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate core clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Holds the integral register |
| kp_gain | input | KP_W (8) | Proportional gain, unsigned |
| ki_gain | input | KI_W (6) | Integral gain, unsigned |
| int_limit | input | INT_W-1 (13) | Magnitude limit of the integral register |
| a_dec | input | 2 | Slice A data decisions (lanes 0,1) |
| a_err | input | 2 | Slice A error signs |
| b_dec | input | 2 | Slice B data decisions |
| b_err | input | 2 | Slice B error signs |
| rot_code | output | CODE_W (7) | Phase rotator control code |
| int_value | output | INT_W (14) | Integral register, signed |

## Verification
The assertions check on every cycle that the vote stays within ±4 and that the integral never leaves the clamp window. They also check that freeze really holds the integral, that the boundary history is cleared by reset, and that a zero vote with a zero integral leaves the rotator code unchanged. What the assertions cannot show is the symbol reordering, the sign of each pair term, the weighting by Kp and Ki, and the one-cycle split between the proportional and integral paths. The bench shows these by sweeping all 256 input codes under several gain and limit settings. It runs an arithmetic model alongside and compares rot_code and int_value after every edge, including across accumulator wrap and saturation.

// File: rtl/mm_cdr_pkg.sv
package mm_cdr_pkg;
  localparam int SYMS  = 4;
  localparam int HALF  = SYMS / 2;
  localparam int VOTE_W = 4;
  typedef logic signed [VOTE_W-1:0] vote_t;
endpackage

// File: rtl/mm_vote_detector.sv
module mm_vote_detector
  import mm_cdr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [HALF-1:0] a_dec,
  input  logic [HALF-1:0] a_err,
  input  logic [HALF-1:0] b_dec,
  input  logic [HALF-1:0] b_err,
  output vote_t           vote
);
  logic [SYMS:0] d_seq, e_seq;  // index 0 = previous word's last symbol
  logic          last_d, last_e, hist_ok;
  logic signed [1:0] term [SYMS];

  assign d_seq[0] = last_d;
  assign e_seq[0] = last_e;

  genvar g;
  generate
    for (g = 0; g < HALF; g++) begin : g_interleave
      assign d_seq[2*g+1] = a_dec[g];
      assign e_seq[2*g+1] = a_err[g];
      assign d_seq[2*g+2] = b_dec[g];
      assign e_seq[2*g+2] = b_err[g];
    end
    for (g = 0; g < SYMS; g++) begin : g_pair
      logic fwd, bwd, live;
      assign fwd  = (e_seq[g+1] == d_seq[g]);
      assign bwd  = (e_seq[g] == d_seq[g+1]);
      assign live = (g != 0) || hist_ok;
      assign term[g] = (!live || fwd == bwd) ? 2'sd0 : (fwd ? 2'sd1 : -2'sd1);
    end
  endgenerate

  always_comb begin
    vote = '0;
    for (int i = 0; i < SYMS; i++) vote = vote + vote_t'(term[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_d  <= 1'b0;
      last_e  <= 1'b0;
      hist_ok <= 1'b0;
    end else begin
      last_d  <= d_seq[SYMS];
      last_e  <= e_seq[SYMS];
      hist_ok <= 1'b1;
    end
  end

  p_vote_range_r2: assert property (@(posedge clk) disable iff (rst)
    (vote >= -4) && (vote <= 4));
  p_hist_cleared_r3: assert property (@(posedge clk) rst |=> !hist_ok);
endmodule

// File: rtl/mm_loop_integrator.sv
module mm_loop_integrator
  import mm_cdr_pkg::*;
#(
  parameter int KI_W  = 6,
  parameter int INT_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    freeze,
  input  vote_t                   vote,
  input  logic [KI_W-1:0]         ki_gain,
  input  logic [INT_W-2:0]        int_limit,
  output logic signed [INT_W-1:0] integ
);
  localparam int PW = KI_W + VOTE_W + 1;
  localparam int SW = INT_W + 1;

  logic signed [PW-1:0] step;
  logic signed [SW-1:0] sum, lim_hi, lim_lo;

  assign step   = vote * $signed({1'b0, ki_gain});
  assign sum    = {integ[INT_W-1], integ} + {{(SW-PW){step[PW-1]}}, step};
  assign lim_hi = $signed({2'b00, int_limit});
  assign lim_lo = -lim_hi;

  always_ff @(posedge clk) begin
    if (rst)          integ <= '0;
    else if (!freeze) begin
      if (sum > lim_hi)      integ <= lim_hi[INT_W-1:0];
      else if (sum < lim_lo) integ <= lim_lo[INT_W-1:0];
      else                   integ <= sum[INT_W-1:0];
    end
  end

  p_clamp_window_r6: assert property (@(posedge clk) disable iff (rst)
    !freeze |=> ($signed({integ[INT_W-1], integ}) <= $past(lim_hi)) &&
                ($signed({integ[INT_W-1], integ}) >= $past(lim_lo)));
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(integ));
endmodule

// File: rtl/mm_phase_accum.sv
module mm_phase_accum
  import mm_cdr_pkg::*;
#(
  parameter int KP_W   = 8,
  parameter int INT_W  = 14,
  parameter int CODE_W = 7,
  parameter int FRAC_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  vote_t                   vote,
  input  logic [KP_W-1:0]         kp_gain,
  input  logic signed [INT_W-1:0] integ,
  output logic [CODE_W-1:0]       rot_code
);
  localparam int PH_W = CODE_W + FRAC_W;
  localparam int PW   = KP_W + VOTE_W + 1;

  logic signed [PW-1:0]   prop;
  logic        [PH_W-1:0] phase, prop_x, integ_x;

  assign prop    = vote * $signed({1'b0, kp_gain});
  assign prop_x  = {{(PH_W-PW){prop[PW-1]}}, prop};
  assign integ_x = {{(PH_W-INT_W){integ[INT_W-1]}}, integ};

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + prop_x + integ_x;
  end

  assign rot_code = phase[PH_W-1 -: CODE_W];

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (vote == 0 && integ == 0) |=> $stable(rot_code));
endmodule

// File: rtl/mm_cdr_top.sv
module mm_cdr_top
  import mm_cdr_pkg::*;
#(
  parameter int KP_W   = 8,
  parameter int KI_W   = 6,
  parameter int INT_W  = 14,
  parameter int CODE_W = 7,
  parameter int FRAC_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    freeze,
  input  logic [KP_W-1:0]         kp_gain,
  input  logic [KI_W-1:0]         ki_gain,
  input  logic [INT_W-2:0]        int_limit,
  input  logic [1:0]              a_dec,
  input  logic [1:0]              a_err,
  input  logic [1:0]              b_dec,
  input  logic [1:0]              b_err,
  output logic [CODE_W-1:0]       rot_code,
  output logic signed [INT_W-1:0] int_value
);
  vote_t vote;

  mm_vote_detector u_det (
    .clk(clk), .rst(rst), .a_dec(a_dec), .a_err(a_err),
    .b_dec(b_dec), .b_err(b_err), .vote(vote)
  );

  mm_loop_integrator #(.KI_W(KI_W), .INT_W(INT_W)) u_int (
    .clk(clk), .rst(rst), .freeze(freeze), .vote(vote),
    .ki_gain(ki_gain), .int_limit(int_limit), .integ(int_value)
  );

  mm_phase_accum #(.KP_W(KP_W), .INT_W(INT_W), .CODE_W(CODE_W),
                   .FRAC_W(FRAC_W)) u_ph (
    .clk(clk), .rst(rst), .vote(vote), .kp_gain(kp_gain),
    .integ(int_value), .rot_code(rot_code)
  );

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (rot_code == '0) && (int_value == '0));
endmodule

// File: tb/mm_cdr_top_bench.sv
module mm_cdr_top_bench;
  logic clk = 1'b0, rst = 1'b1, freeze = 1'b0;
  logic [7:0]  kp = '0;
  logic [5:0]  ki = '0;
  logic [12:0] lim = '0;
  logic [7:0]  code = '0;
  logic [6:0]  rot;
  logic signed [13:0] ival;

  always #4 clk = ~clk;

  mm_cdr_top u_mm_cdr_top (
    .clk(clk), .rst(rst), .freeze(freeze), .kp_gain(kp), .ki_gain(ki),
    .int_limit(lim), .a_dec(code[1:0]), .a_err(code[3:2]),
    .b_dec(code[5:4]), .b_err(code[7:6]), .rot_code(rot), .int_value(ival)
  );

  int vectors = 0, errors = 0;
  int m_ph = 0, m_int = 0, m_pd = 0, m_pe = 0, m_ok = 0;
  bit done = 0;

  function automatic int pm(input logic b);
    return b ? 1 : -1;
  endfunction

  // R1 order: A0, B0, A1, B1 ; R2 pair term (e[k]d[k-1]-e[k-1]d[k])/2
  function automatic int model_vote(input logic [7:0] c);
    int d[5], e[5], v;
    d[0] = m_pd; e[0] = m_pe;
    d[1] = pm(c[0]); e[1] = pm(c[2]);
    d[2] = pm(c[4]); e[2] = pm(c[6]);
    d[3] = pm(c[1]); e[3] = pm(c[3]);
    d[4] = pm(c[5]); e[4] = pm(c[7]);
    v = 0;
    for (int k = 1; k <= 4; k++)
      if (k > 1 || m_ok != 0) v += (e[k]*d[k-1] - e[k-1]*d[k]) / 2;
    return v;
  endfunction

  task automatic apply(input logic [7:0] c, input string tag);
    int v, s;
    @(negedge clk);
    code = c;
    if (rst) begin
      m_ph = 0; m_int = 0; m_ok = 0; m_pd = 0; m_pe = 0;
    end else begin
      v = model_vote(c);
      m_ph = (m_ph + v*int'(kp) + m_int) & 16'hFFFF;
      if (!freeze) begin
        s = m_int + v*int'(ki);
        if (s > int'(lim)) s = int'(lim);
        if (s < -int'(lim)) s = -int'(lim);
        m_int = s;
      end
      m_pd = pm(c[5]); m_pe = pm(c[7]); m_ok = 1;
    end
    @(posedge clk); #1;
    vectors++;
    if (rot !== 7'(m_ph >> 9)) begin
      errors++;
      $display("FAIL %s rot_code actual=%0d expected=%0d", tag, rot, m_ph >> 9);
    end
    vectors++;
    if (int'(ival) != m_int) begin
      errors++;
      $display("FAIL %s/R10 int_value actual=%0d expected=%0d", tag, ival, m_int);
    end
  endtask

  task automatic sweep(input int n, input int seed, input string tag);
    logic [7:0] lf = 8'(seed);
    for (int i = 0; i < n; i++) begin
      apply(lf ^ 8'(i), tag);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    rst = 1'b1;
    apply(8'hA5, "R9 reset");
    apply(8'h3C, "R9 reset");
    rst = 1'b0;
    // R3 first word boundary, R1/R2/R4 proportional only
    kp = 8'd5; ki = '0; lim = 13'd100;
    apply(8'h0F, "R3 first word");
    for (int c = 0; c < 256; c++) apply(8'(c), "R1/R2/R4");
    // R8 wrap with large Kp
    kp = 8'd255;
    sweep(512, 8'h1D, "R8 wrap");
    // R5 integral with wide limit
    kp = 8'd3; ki = 6'd7; lim = 13'd8000;
    sweep(512, 8'h5B, "R5 integral");
    // R6 saturation at small limit
    ki = 6'd63; lim = 13'd40;
    sweep(512, 8'h91, "R6 clamp");
    lim = 13'd8191;
    sweep(512, 8'h27, "R6 full range");
    lim = 13'd10;
    sweep(64, 8'hC3, "R6 shrink");
    // R7 freeze
    lim = 13'd2000; ki = 6'd20;
    sweep(64, 8'h44, "R5 preload");
    freeze = 1'b1;
    sweep(256, 8'h6E, "R7 freeze");
    freeze = 1'b0;
    sweep(128, 8'hB2, "R7 release");
    // R9 mid-run reset then R3 again
    rst = 1'b1;
    apply(8'hFF, "R9 mid reset");
    rst = 1'b0;
    for (int c = 0; c < 256; c++) begin
      rst = (c % 37 == 0);
      apply(8'(c * 7 + 1), "R3/R9 reseeded");
    end
    rst = 1'b0;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule